// File: doc/BRIEF.md
# Lane-Selectable Event Counter

This block counts occurrences of a single event chosen from a large vector of event pulses produced by a multi-lane serial link. Each pulse line is identified by three coordinates: a group number, an event number within that group, and a lane number. Software picks one line by writing a 32-bit control word. The same write can start or stop counting and can zero the count. The running total is read back from a 32-bit data word.

Access is through a plain register port made of a write strobe, a read strobe, a word address, 32-bit write data and registered 32-bit read data. The control word sits at word address 2 (byte offset 0x8) and the count at word address 3 (byte offset 0xC). The start, stop and clear controls are command codes that take effect once, in the cycle of the write. They are not levels that are held. A new selection does not clear the count; zeroing it is always an explicit command.

Top module: `lane_evt_counter`

## Requirements
- R1: While and after synchronous reset, counting is off, the selection is zero and the count is zero, so both registers read 0.
- R2: A control read returns the group in bits 27:24, the event number in bits 23:16, the lane in bits 11:8 and the counting status in bit 7 (1 = counting). All other bits read 0.
- R3: While counting is on, every clock cycle in which the selected line, at flat index (group*EVENTS + event)*LANES + lane, is high adds exactly one to the count.
- R4: A control write with command bits 4:2 = 3'b011 turns counting on, and 3'b001 turns it off. Any other code leaves the counting state as it was.
- R5: A control write with bits 1:0 = 2'b01 zeroes the count in that cycle, and it overrides a coincident increment. Other codes in bits 1:0 leave the count alone.
- R6: A control write that changes group, event or lane without the clear code keeps the accumulated count.
- R7: The count wraps to 0 after its all-ones value (modulo 2^CNT_W) and is zero-extended onto the 32-bit data word.
- R8: Event lines other than the selected one never change the count. A selection whose group, event or lane lies outside the built range counts nothing.
- R9: A single control write that carries new select values, the stop code and the clear code latches the selection, stops counting and zeroes the count together.
- R10: Read data appears on the cycle after the read strobe and holds until the next read. A read of any word address other than 2 or 3 returns 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | ADDR_W | Word address |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Registered read data |
| evt_in | input | GROUPS*EVENTS*LANES | Event pulse lines, flat index (group*EVENTS+event)*LANES+lane |

## Verification
The bench builds the block with GROUPS=3, EVENTS=5 and LANES=2. Because none of these fills its 4- or 8-bit select field, out-of-range groups, events and lanes can be written and shown to count nothing. The counter is built 8 bits wide, so a run of 260 pulses crosses the wrap point and the zero-extension onto the data word shows in the upper bits. The adjacent-lane line and the all-lines-high pattern are used to show that only the single selected input reaches the counter.

// File: rtl/lec_pkg.sv
package lec_pkg;

  // word addresses of the two registers (byte offsets 0x8 and 0xC)
  localparam int unsigned CTRL_WORD = 2;
  localparam int unsigned DATA_WORD = 3;

  // command codes carried in the control word
  localparam logic [2:0] RUN_ON  = 3'b011;
  localparam logic [2:0] RUN_OFF = 3'b001;
  localparam logic [1:0] ZERO_GO = 2'b01;

  typedef struct packed {
    logic [3:0] grp;
    logic [7:0] num;
    logic [3:0] lane;
  } lec_sel_t;

endpackage

// File: rtl/lec_ctrl.sv
module lec_ctrl
  import lec_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       wr_ctrl,
  input  lec_sel_t   sel_in,
  input  logic [2:0] run_cmd,
  input  logic [1:0] zero_cmd,
  output lec_sel_t   sel_q,
  output logic       en_q,
  output logic       clr_go
);

  // the clear command is a one-cycle pulse tied to the write itself
  assign clr_go = wr_ctrl && (zero_cmd == ZERO_GO);

  always_ff @(posedge clk) begin
    if (rst) begin
      sel_q <= '0;
      en_q  <= 1'b0;
    end else if (wr_ctrl) begin
      sel_q <= sel_in;
      if (run_cmd == RUN_ON)
        en_q <= 1'b1;
      else if (run_cmd == RUN_OFF)
        en_q <= 1'b0;
    end
  end

endmodule

// File: rtl/lec_evt_mux.sv
module lec_evt_mux
  import lec_pkg::*;
#(
  parameter int GROUPS = 8,
  parameter int EVENTS = 4,
  parameter int LANES  = 4,
  localparam int TOTAL = GROUPS * EVENTS * LANES,
  localparam int IDX_W = (TOTAL > 1) ? $clog2(TOTAL) : 1
) (
  input  logic [TOTAL-1:0] evt_in,
  input  lec_sel_t         sel,
  output logic             hit
);

  logic        grp_ok, num_ok, lane_ok;
  logic [31:0] flat_idx;

  // a field that fully covers its range needs no comparator
  generate
    if (GROUPS >= 16) begin : g_grp_all
      assign grp_ok = 1'b1;
    end else begin : g_grp_cmp
      assign grp_ok = (32'(sel.grp) < GROUPS);
    end
    if (EVENTS >= 256) begin : g_num_all
      assign num_ok = 1'b1;
    end else begin : g_num_cmp
      assign num_ok = (32'(sel.num) < EVENTS);
    end
    if (LANES >= 16) begin : g_lane_all
      assign lane_ok = 1'b1;
    end else begin : g_lane_cmp
      assign lane_ok = (32'(sel.lane) < LANES);
    end
    if (IDX_W < 32) begin : g_idx_hi
      logic unused_idx_hi;
      assign unused_idx_hi = ^flat_idx[31:IDX_W];
    end
  endgenerate

  assign flat_idx = ((32'(sel.grp) * EVENTS) + 32'(sel.num)) * LANES + 32'(sel.lane);

  assign hit = grp_ok && num_ok && lane_ok && evt_in[flat_idx[IDX_W-1:0]];

endmodule

// File: rtl/lec_counter.sv
module lec_counter #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             inc,
  output logic [CNT_W-1:0] cnt_q
);

  // clear wins over a coincident increment
  always_ff @(posedge clk) begin
    if (rst || clr)
      cnt_q <= '0;
    else if (inc)
      cnt_q <= cnt_q + CNT_W'(1);
  end

endmodule

// File: rtl/lane_evt_counter.sv
module lane_evt_counter
  import lec_pkg::*;
#(
  parameter int GROUPS = 8,
  parameter int EVENTS = 4,
  parameter int LANES  = 4,
  parameter int CNT_W  = 32,
  parameter int ADDR_W = 4,
  localparam int TOTAL = GROUPS * EVENTS * LANES
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [31:0]       wdata,
  output logic [31:0]       rdata,
  input  logic [TOTAL-1:0]  evt_in
);

  lec_sel_t         sel_in, sel_q;
  logic             wr_ctrl, en_q, clr_go, hit;
  logic [CNT_W-1:0] cnt_q;
  logic [31:0]      rd_mux;
  logic             unused_wbits;

  assign wr_ctrl = wr_en && (addr == ADDR_W'(CTRL_WORD));
  assign sel_in  = '{grp: wdata[27:24], num: wdata[23:16], lane: wdata[11:8]};
  assign unused_wbits = ^{wdata[31:28], wdata[15:12], wdata[7:5]};

  lec_ctrl u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .wr_ctrl  (wr_ctrl),
    .sel_in   (sel_in),
    .run_cmd  (wdata[4:2]),
    .zero_cmd (wdata[1:0]),
    .sel_q    (sel_q),
    .en_q     (en_q),
    .clr_go   (clr_go)
  );

  lec_evt_mux #(
    .GROUPS (GROUPS),
    .EVENTS (EVENTS),
    .LANES  (LANES)
  ) u_mux (
    .evt_in (evt_in),
    .sel    (sel_q),
    .hit    (hit)
  );

  lec_counter #(
    .CNT_W (CNT_W)
  ) u_cnt (
    .clk   (clk),
    .rst   (rst),
    .clr   (clr_go),
    .inc   (en_q && hit),
    .cnt_q (cnt_q)
  );

  always_comb begin
    if (addr == ADDR_W'(CTRL_WORD))
      rd_mux = {4'b0, sel_q.grp, sel_q.num, 4'b0, sel_q.lane, en_q, 7'b0};
    else if (addr == ADDR_W'(DATA_WORD))
      rd_mux = 32'(cnt_q);
    else
      rd_mux = '0;
  end

  always_ff @(posedge clk) begin
    if (rst)
      rdata <= '0;
    else if (rd_en)
      rdata <= rd_mux;
  end

endmodule

// File: rtl/lec_checker.sv
module lec_checker
  import lec_pkg::*;
#(
  parameter int CNT_W  = 32,
  parameter int ADDR_W = 4
) (
  input logic              clk,
  input logic              rst,
  input logic              wr_en,
  input logic              rd_en,
  input logic [ADDR_W-1:0] addr,
  input logic [31:0]       wdata,
  input logic [31:0]       rdata,
  input logic              en_q,
  input logic              hit,
  input logic              clr_go,
  input logic [CNT_W-1:0]  cnt_q
);

  logic wr_c;
  assign wr_c = wr_en && (addr == ADDR_W'(CTRL_WORD));

  a_r1_reset_idle: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (cnt_q == '0 && !en_q && rdata == '0));

  a_r3_single_step: assert property (@(posedge clk) disable iff (rst)
    (!clr_go && en_q && hit) |=> (cnt_q == CNT_W'($past(cnt_q) + CNT_W'(1))));

  a_r8_no_hit_hold: assert property (@(posedge clk) disable iff (rst)
    (!clr_go && !(en_q && hit)) |=> $stable(cnt_q));

  a_r5_clear_zero: assert property (@(posedge clk) disable iff (rst)
    (wr_c && wdata[1:0] == ZERO_GO) |=> (cnt_q == '0));

  a_r4_turn_on: assert property (@(posedge clk) disable iff (rst)
    (wr_c && wdata[4:2] == RUN_ON) |=> en_q);

  a_r4_turn_off: assert property (@(posedge clk) disable iff (rst)
    (wr_c && wdata[4:2] == RUN_OFF) |=> !en_q);

  a_r4_other_hold: assert property (@(posedge clk) disable iff (rst)
    (!wr_c || (wdata[4:2] != RUN_ON && wdata[4:2] != RUN_OFF)) |=> $stable(en_q));

  a_r7_wrap: assert property (@(posedge clk) disable iff (rst)
    (!clr_go && en_q && hit && cnt_q == '1) |=> (cnt_q == '0));

  a_r10_unmapped_zero: assert property (@(posedge clk) disable iff (rst)
    (rd_en && addr != ADDR_W'(CTRL_WORD) && addr != ADDR_W'(DATA_WORD)) |=> (rdata == '0));

  a_r10_read_hold: assert property (@(posedge clk) disable iff (rst)
    !rd_en |=> $stable(rdata));

endmodule

bind lane_evt_counter lec_checker #(
  .CNT_W  (CNT_W),
  .ADDR_W (ADDR_W)
) u_lec_checker (
  .clk    (clk),
  .rst    (rst),
  .wr_en  (wr_en),
  .rd_en  (rd_en),
  .addr   (addr),
  .wdata  (wdata),
  .rdata  (rdata),
  .en_q   (en_q),
  .hit    (hit),
  .clr_go (clr_go),
  .cnt_q  (cnt_q)
);

// File: tb/test_lane_evt_counter.sv
`timescale 1ns/1ps
module test_lane_evt_counter;

  localparam int G = 3, E = 5, L = 2, CW = 8, AW = 4;
  localparam int TOT = G * E * L;

  logic           clk = 1'b0;
  logic           rst = 1'b1;
  logic           wr_en = 1'b0, rd_en = 1'b0;
  logic [AW-1:0]  addr = '0;
  logic [31:0]    wdata = '0;
  logic [31:0]    rdata;
  logic [TOT-1:0] evt_in = '0;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  logic [31:0] exp_q[$];
  string       tag_q[$];
  logic        pend = 1'b0;

  always #4 clk = ~clk;

  lane_evt_counter #(
    .GROUPS (G), .EVENTS (E), .LANES (L), .CNT_W (CW), .ADDR_W (AW)
  ) i_lane_evt_counter (
    .clk (clk), .rst (rst), .wr_en (wr_en), .rd_en (rd_en),
    .addr (addr), .wdata (wdata), .rdata (rdata), .evt_in (evt_in)
  );

  function automatic logic [31:0] cw(int g, int e, int l, logic [2:0] run, logic [1:0] zr);
    return {4'b0, 4'(g), 8'(e), 4'b0, 4'(l), 3'b0, run, zr};
  endfunction

  function automatic logic [31:0] rb(int g, int e, int l, logic st);
    return {4'b0, 4'(g), 8'(e), 4'b0, 4'(l), st, 7'b0};
  endfunction

  function automatic int fidx(int g, int e, int l);
    return (g * E + e) * L + l;
  endfunction

  task automatic wr(input logic [31:0] d);
    wr_en = 1'b1; addr = AW'(2); wdata = d;
    @(negedge clk);
    wr_en = 1'b0; wdata = '0;
  endtask

  task automatic rd(input int a, input logic [31:0] expv, input string tag);
    exp_q.push_back(expv); tag_q.push_back(tag);
    rd_en = 1'b1; addr = AW'(a);
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic pulse(input int idx, input int n);
    evt_in[idx] = 1'b1;
    repeat (n) @(negedge clk);
    evt_in[idx] = 1'b0;
  endtask

  // monitor: read data is valid at the negedge after the read strobe edge
  always @(posedge clk) pend <= rd_en;

  initial begin
    forever begin
      @(negedge clk);
      if (pend && exp_q.size() > 0) begin
        logic [31:0] e;
        string t;
        e = exp_q.pop_front(); t = tag_q.pop_front();
        checks++;
        if (rdata !== e) begin
          errors++;
          $display("FAIL %s: actual %h expected %h", t, rdata, e);
        end
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    rd(2, 32'h0, "R1 ctrl after reset");
    rd(3, 32'h0, "R1 data after reset");

    wr(cw(1, 3, 1, 3'b011, 2'b01));
    rd(2, rb(1, 3, 1, 1'b1), "R2 ctrl layout");
    pulse(fidx(1, 3, 1), 7);
    rd(3, 32'd7, "R3 seven pulses");

    pulse(fidx(1, 3, 0), 5);
    rd(3, 32'd7, "R8 neighbour lane ignored");

    wr(cw(1, 3, 1, 3'b101, 2'b00));
    rd(2, rb(1, 3, 1, 1'b1), "R4 other code keeps on");
    pulse(fidx(1, 3, 1), 2);
    rd(3, 32'd9, "R4 still counting");

    wr(cw(1, 3, 1, 3'b001, 2'b00));
    rd(2, rb(1, 3, 1, 1'b0), "R4 off status");
    pulse(fidx(1, 3, 1), 4);
    rd(3, 32'd9, "R4 off no count");

    wr(cw(2, 0, 0, 3'b011, 2'b00));
    rd(3, 32'd9, "R6 reselect keeps count");
    pulse(fidx(2, 0, 0), 3);
    rd(3, 32'd12, "R3 new selection counts");

    wr(cw(2, 0, 0, 3'b000, 2'b10));
    rd(3, 32'd12, "R5 non-clear code");
    evt_in[fidx(2, 0, 0)] = 1'b1;
    wr(cw(2, 0, 0, 3'b000, 2'b01));
    evt_in[fidx(2, 0, 0)] = 1'b0;
    rd(3, 32'd0, "R5 clear beats event");
    rd(2, rb(2, 0, 0, 1'b1), "R5 clear keeps enable");

    pulse(fidx(2, 0, 0), 260);
    rd(3, 32'd4, "R7 wrap modulo 256");

    wr(cw(2, 7, 0, 3'b011, 2'b00));
    evt_in = '1;
    repeat (5) @(negedge clk);
    evt_in = '0;
    rd(3, 32'd4, "R8 event out of range");
    wr(cw(0, 0, 3, 3'b011, 2'b00));
    evt_in = '1;
    repeat (5) @(negedge clk);
    evt_in = '0;
    rd(3, 32'd4, "R8 lane out of range");

    wr(cw(0, 0, 0, 3'b011, 2'b00));
    pulse(fidx(0, 0, 0), 3);
    rd(3, 32'd7, "R3 group zero");
    evt_in[fidx(0, 0, 0)] = 1'b1;
    wr(cw(1, 1, 1, 3'b001, 2'b01));
    evt_in[fidx(0, 0, 0)] = 1'b0;
    rd(2, rb(1, 1, 1, 1'b0), "R9 combined select/stop");
    rd(3, 32'd0, "R9 combined clear");
    pulse(fidx(1, 1, 1), 4);
    rd(3, 32'd0, "R9 stopped after combined");

    rd(5, 32'd0, "R10 unmapped reads zero");
    repeat (3) @(negedge clk);
    checks++;
    if (rdata !== 32'd0) begin
      errors++;
      $display("FAIL R10 hold after read: actual %h expected %h", rdata, 32'd0);
    end

    repeat (2) @(negedge clk);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule